// File: doc/BRIEF.md
# Dual-Plane Scanout Pixel Formatter

This block is the colour stage of a display scanout path. Every accepted input beat carries three things for one pixel: an 8-bit colour index, a 32-bit control-plane word and a 32-bit direct-colour word. A tag in the control word chooses between two sources. One is a 256-entry palette lookup. The other is a 24-bit true colour taken straight from the direct word. The chosen red/green/blue triple is then packed into one of four output encodings: 8, 15, 16 or 32 bits per pixel.

Upstream fetch logic delivers raster lines on a fixed stride of 1024 pixels. The block tracks its own position in the raster. Only the first `width_i` pixels of each line are emitted. The frame wraps after `height_i` lines. Both streams use valid/ready handshakes. The palette RAM has its own write port, driven by a palette controller. The output format and the true-colour mode are captured once per frame, on the frame's first pixel.

Top module: `scan_pixel_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The tag byte is bits 7:0 of `in_ctrl` (the top byte of the byte-swapped word). A pixel is direct colour only when this byte equals 0x03, the frame's format is 32-bit and true-colour mode is on. The other three bytes of `in_ctrl` do not matter.
- R3: A direct pixel takes red from `in_direct[7:0]`, green from `in_direct[15:8]` and blue from `in_direct[23:16]`. `in_direct[31:24]` is ignored. Output bits 31:24 are always 0.
- R4: Any other pixel uses `in_index` to read a 256-entry palette. The palette is written through `pal_we`/`pal_addr`/`pal_data`, where `pal_data` holds red in bits 23:16, green in 15:8 and blue in 7:0.
- R5: Format code 0 (8-bit) gives {R[7:5],G[7:5],B[7:6]} in bits 7:0. Format code 1 (15-bit) gives {R[7:3],G[7:3],B[7:3]} in bits 14:0. All higher bits are 0.
- R6: Format code 2 (16-bit) gives {R[7:3],G[7:2],B[7:3]} in bits 15:0. Format code 3 (32-bit) gives {R,G,B} in bits 23:0.
- R7: When true-colour mode is off (`tc_mode_i`=0), or the format is not 3, a pixel tagged 0x03 still goes through the palette.
- R8: Every line consumes exactly 1024 input beats. Only beats at x < `width_i` produce output. The others are dropped. After `height_i` lines, the next beat is the frame origin.
- R9: `out_sof` marks the output of the origin pixel. `out_eol` marks the output of the pixel at x = `width_i`-1.
- R10: `fmt_i` and `tc_mode_i` are sampled on the origin beat and hold for the whole frame. A change in the middle of a frame first applies to the next frame.
- R11: `in_ready` is high whenever the output register is empty or is being drained. A stalled output holds its value. Pixels are never lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Output format code (0:8, 1:15, 2:16, 3:32 bit) |
| tc_mode_i | input | 1 | True-colour mode enable |
| width_i | input | 11 | Active pixels per line (1..1024) |
| height_i | input | 10 | Lines per frame (1..768) |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 8 | Palette write address |
| pal_data | input | 24 | Palette entry {R,G,B} |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with valid |
| in_index | input | 8 | Palette index |
| in_ctrl | input | 32 | Control-plane word |
| in_direct | input | 32 | Direct-colour word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_pixel | output | 32 | Packed pixel |
| out_sof | output | 1 | Output is frame origin |
| out_eol | output | 1 | Output is last active pixel of its line |

## Verification
Several properties are checked on every cycle:
- A stalled output keeps its value.
- The bits above each format's width stay zero, and the top byte is always zero.
- A pixel flagged direct only ever appears in 32-bit frames.
- The raster returns to the origin after the last beat of the last line.

The bench scenarios cover what no single cycle can show:
- each packing value, computed by hand from palette contents;
- tag decoding on the swapped byte;
- dropping of pixels beyond the active width;
- frame-start capture of a format changed mid-frame;
- lossless ordering under irregular backpressure.

// File: rtl/spp_pkg.sv
package spp_pkg;
  typedef enum logic [1:0] {
    PF_8  = 2'd0,
    PF_15 = 2'd1,
    PF_16 = 2'd2,
    PF_32 = 2'd3
  } pix_fmt_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam logic [7:0] DIRECT_TAG = 8'h03;

  function automatic logic [31:0] pack_px(rgb_t c, pix_fmt_e f);
    case (f)
      PF_8:    return {24'd0, c.r[7:5], c.g[7:5], c.b[7:6]};
      PF_15:   return {17'd0, c.r[7:3], c.g[7:3], c.b[7:3]};
      PF_16:   return {16'd0, c.r[7:3], c.g[7:2], c.b[7:3]};
      default: return {8'd0, c.r, c.g, c.b};
    endcase
  endfunction
endpackage

// File: rtl/spp_palette.sv
module spp_palette #(
  parameter int IDX_W = 8,
  parameter int DAT_W = 24
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DAT_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [DAT_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem [0:DEPTH-1];

  // simple dual-port, read-first, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spp_raster.sv
module spp_raster #(
  parameter int STRIDE = 1024,
  parameter int MAX_H  = 768,
  localparam int XW = $clog2(STRIDE),
  localparam int WW = XW + 1,
  localparam int YW = $clog2(MAX_H)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [WW-1:0] width_i,
  input  logic [YW-1:0] height_i,
  output logic          at_origin,
  output logic          active,
  output logic          line_end
);
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic          x_last, y_last;

  assign x_last    = (x_q == XW'(STRIDE - 1));
  assign y_last    = (y_q == height_i - YW'(1));
  assign at_origin = (x_q == '0) && (y_q == '0);
  assign active    = ({1'b0, x_q} < width_i);
  assign line_end  = ({1'b0, x_q} == width_i - WW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (adv) begin
      if (x_last) begin
        x_q <= '0;
        y_q <= y_last ? '0 : y_q + YW'(1);
      end else begin
        x_q <= x_q + XW'(1);
      end
    end
  end

  // R8: the last beat of the last line returns to the origin
  a_r8_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && x_last && y_last) |=> at_origin);
endmodule

// File: rtl/scan_pixel_packer.sv
module scan_pixel_packer
  import spp_pkg::*;
#(
  parameter int STRIDE = 1024,
  parameter int MAX_H  = 768,
  parameter int IDX_W  = 8,
  parameter int CW_W   = 32,
  parameter int PIX_W  = 32,
  localparam int WW = $clog2(STRIDE) + 1,
  localparam int YW = $clog2(MAX_H)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       fmt_i,
  input  logic             tc_mode_i,
  input  logic [WW-1:0]    width_i,
  input  logic [YW-1:0]    height_i,
  input  logic             pal_we,
  input  logic [IDX_W-1:0] pal_addr,
  input  logic [23:0]      pal_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  input  logic [CW_W-1:0]  in_ctrl,
  input  logic [CW_W-1:0]  in_direct,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pixel,
  output logic             out_sof,
  output logic             out_eol
);
  logic     en, accept;
  logic     at_origin, active, line_end;
  pix_fmt_e fmt_q, eff_fmt;
  logic     tc_q, eff_tc;
  logic [23:0] pal_q;

  // stage 1 (aligned with palette read)
  logic     v1, dir1, sof1, eol1;
  rgb_t     rgb1;
  pix_fmt_e f1;
  // stage 2 (output)
  logic     v2, dir2;
  pix_fmt_e f2;
  rgb_t     sel_rgb;

  assign en       = !v2 || out_ready;
  assign in_ready = en;
  assign accept   = in_valid && en;

  assign eff_fmt = at_origin ? pix_fmt_e'(fmt_i) : fmt_q;
  assign eff_tc  = at_origin ? tc_mode_i : tc_q;

  spp_raster #(.STRIDE(STRIDE), .MAX_H(MAX_H)) u_raster (
    .clk(clk), .rst(rst), .adv(accept),
    .width_i(width_i), .height_i(height_i),
    .at_origin(at_origin), .active(active), .line_end(line_end)
  );

  spp_palette #(.IDX_W(IDX_W), .DAT_W(24)) u_pal (
    .clk(clk), .we(pal_we), .waddr(pal_addr), .wdata(pal_data),
    .re(en), .raddr(in_index), .rdata(pal_q)
  );

  // frame-start capture of format and mode
  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q <= PF_8;
      tc_q  <= 1'b0;
    end else if (accept && at_origin) begin
      fmt_q <= pix_fmt_e'(fmt_i);
      tc_q  <= tc_mode_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
    end else if (en) begin
      v1 <= accept && active;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      dir1 <= eff_tc && (eff_fmt == PF_32) && (in_ctrl[7:0] == DIRECT_TAG);
      rgb1 <= '{r: in_direct[7:0], g: in_direct[15:8], b: in_direct[23:16]};
      f1   <= eff_fmt;
      sof1 <= at_origin;
      eol1 <= line_end;
    end
  end

  assign sel_rgb = dir1 ? rgb1 : rgb_t'(pal_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0;
    end else if (en) begin
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_pixel <= PIX_W'(pack_px(sel_rgb, f1));
      out_sof   <= sof1;
      out_eol   <= eol1;
      dir2      <= dir1;
      f2        <= f1;
    end
  end

  assign out_valid = v2;

  // R11: a stalled output holds
  a_r11_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)
                                   && $stable(out_sof) && $stable(out_eol)));
  // R3: top byte never set
  a_r3_top_byte_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pixel[31:24] == 8'd0));
  // R5: narrow formats leave upper bits clear
  a_r5_fmt8_upper: assert property (@(posedge clk) disable iff (rst)
    (out_valid && f2 == PF_8) |-> (out_pixel[31:8] == '0));
  a_r5_fmt15_upper: assert property (@(posedge clk) disable iff (rst)
    (out_valid && f2 == PF_15) |-> (out_pixel[31:15] == '0));
  // R7: direct colour only in 32-bit frames
  a_r7_direct_only_32: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dir2) |-> (f2 == PF_32));
endmodule

// File: tb/scan_pixel_packer_test.sv
`timescale 1ns/1ps
module scan_pixel_packer_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  fmt_i;
  logic        tc_mode_i;
  logic [10:0] width_i;
  logic [9:0]  height_i;
  logic        pal_we;
  logic [7:0]  pal_addr;
  logic [23:0] pal_data;
  logic        in_valid, in_ready;
  logic [7:0]  in_index;
  logic [31:0] in_ctrl, in_direct;
  logic        out_valid, out_ready, out_sof, out_eol;
  logic [31:0] out_pixel;

  int checks = 0;
  int errors = 0;

  logic [33:0] cap [0:63];
  int ncap = 0;

  always #4 clk = ~clk;

  scan_pixel_packer uut (
    .clk(clk), .rst(rst), .fmt_i(fmt_i), .tc_mode_i(tc_mode_i),
    .width_i(width_i), .height_i(height_i),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_data(pal_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
    .in_ctrl(in_ctrl), .in_direct(in_direct),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  // capture outputs that complete at the next rising edge
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && ncap < 64) begin
      cap[ncap] = {out_sof, out_eol, out_pixel};
      ncap = ncap + 1;
    end
  end

  // table: {fmt, tc_mode, index, ctrl, direct, expected}
  localparam int NV = 12;
  localparam logic [106:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'd5,   32'h0,        32'h0,        32'h000000AB}, // R5 8-bit
    {2'd1, 1'b0, 8'd5,   32'h0,        32'h0,        32'h00005979}, // R5 15-bit
    {2'd2, 1'b0, 8'd5,   32'h0,        32'h0,        32'h0000B2F9}, // R6 16-bit
    {2'd3, 1'b0, 8'd5,   32'h0,        32'h0,        32'h00B65DC9}, // R6 32-bit
    {2'd3, 1'b1, 8'd5,   32'h00000003, 32'hAA332211, 32'h00112233}, // R2 R3 direct
    {2'd3, 1'b1, 8'd5,   32'h03000000, 32'hAA332211, 32'h00B65DC9}, // R2 unswapped tag
    {2'd3, 1'b1, 8'd5,   32'hFFFFFF03, 32'h55FFEEDD, 32'h00DDEEFF}, // R2 R3 other bytes
    {2'd2, 1'b1, 8'd5,   32'h00000003, 32'hAA332211, 32'h0000B2F9}, // R7 not 32-bit
    {2'd3, 1'b0, 8'd5,   32'h00000003, 32'hAA332211, 32'h00B65DC9}, // R7 mode off
    {2'd1, 1'b0, 8'd255, 32'h0,        32'h0,        32'h00007FFF}, // R4 R5 index 255
    {2'd2, 1'b0, 8'd7,   32'h0,        32'h0,        32'h000011AA}, // R4 R6 index 7
    {2'd0, 1'b0, 8'd0,   32'h0,        32'h0,        32'h00000000}  // R4 R5 index 0
  };

  task automatic chk(input logic ok, input string req, input logic [33:0] act,
                     input logic [33:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] idx, input logic [31:0] c,
                      input logic [31:0] d);
    logic rdy;
    in_valid = 1'b1; in_index = idx; in_ctrl = c; in_direct = d;
    do begin
      @(negedge clk); rdy = in_ready;
      @(posedge clk); #1;
    end while (!rdy);
    in_valid = 1'b0;
  endtask

  task automatic pal_write(input logic [7:0] a, input logic [23:0] v);
    pal_we = 1'b1; pal_addr = a; pal_data = v;
    @(posedge clk); #1;
    pal_we = 1'b0;
  endtask

  task automatic drain();
    repeat (6) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; fmt_i = 2'd0; tc_mode_i = 1'b0; width_i = 11'd1; height_i = 10'd1;
    pal_we = 1'b0; pal_addr = '0; pal_data = '0;
    in_valid = 1'b0; in_index = '0; in_ctrl = '0; in_direct = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", {33'd0, out_valid}, 34'd0);
    chk(in_ready == 1'b1, "R1 in_ready", {33'd0, in_ready}, 34'd1);
    @(posedge clk); #1;

    pal_write(8'd0,   24'h000000);
    pal_write(8'd5,   24'hB65DC9);
    pal_write(8'd7,   24'h123456);
    pal_write(8'd255, 24'hFFFFFF);

    // table: one-pixel frames, one line each
    for (int i = 0; i < NV; i++) begin
      ncap = 0;
      width_i = 11'd1; height_i = 10'd1;
      fmt_i = VEC[i][106:105]; tc_mode_i = VEC[i][104];
      send(VEC[i][103:96], VEC[i][95:64], VEC[i][63:32]);
      for (int k = 1; k < 1024; k++) send(8'd255, 32'h0, 32'h0);
      drain();
      chk(ncap == 1 && cap[0] == {2'b11, VEC[i][31:0]},
          $sformatf("R5 R6 R2 R3 R4 R7 R9 vec%0d n=%0d", i, ncap),
          cap[0], {2'b11, VEC[i][31:0]});
    end

    // R8 R9: width 3, two lines; beats past width carry index 0 and are dropped
    ncap = 0; width_i = 11'd3; height_i = 10'd2; fmt_i = 2'd3; tc_mode_i = 1'b0;
    for (int y = 0; y < 2; y++)
      for (int x = 0; x < 1024; x++)
        send(x == 0 ? 8'd5 : x == 1 ? 8'd7 : x == 2 ? 8'd255 : 8'd0, 32'h0, 32'h0);
    drain();
    chk(ncap == 6, "R8 active count", 34'(ncap), 34'd6);
    chk(cap[0] == {2'b10, 32'h00B65DC9}, "R9 sof first", cap[0], {2'b10, 32'h00B65DC9});
    chk(cap[1] == {2'b00, 32'h00123456}, "R8 second", cap[1], {2'b00, 32'h00123456});
    chk(cap[2] == {2'b01, 32'h00FFFFFF}, "R9 eol line0", cap[2], {2'b01, 32'h00FFFFFF});
    chk(cap[3] == {2'b00, 32'h00B65DC9}, "R8 line1 no sof", cap[3], {2'b00, 32'h00B65DC9});
    chk(cap[5] == {2'b01, 32'h00FFFFFF}, "R9 eol line1", cap[5], {2'b01, 32'h00FFFFFF});

    // R10: format change mid-frame applies to the next frame
    ncap = 0; width_i = 11'd2; height_i = 10'd1; fmt_i = 2'd3;
    send(8'd5, 32'h0, 32'h0);
    fmt_i = 2'd0;
    for (int k = 1; k < 1024; k++) send(8'd5, 32'h0, 32'h0);
    send(8'd5, 32'h0, 32'h0);
    for (int k = 1; k < 1024; k++) send(8'd5, 32'h0, 32'h0);
    drain();
    chk(ncap == 4, "R10 count", 34'(ncap), 34'd4);
    chk(cap[1] == {2'b01, 32'h00B65DC9}, "R10 held in frame", cap[1], {2'b01, 32'h00B65DC9});
    chk(cap[2] == {2'b10, 32'h000000AB}, "R10 next frame", cap[2], {2'b10, 32'h000000AB});

    // R11: irregular backpressure, order and count preserved
    ncap = 0; width_i = 11'd3; height_i = 10'd1; fmt_i = 2'd3;
    fork
      begin
        send(8'd7, 32'h0, 32'h0);
        send(8'd255, 32'h0, 32'h0);
        send(8'd5, 32'h0, 32'h0);
        for (int k = 3; k < 1024; k++) send(8'd0, 32'h0, 32'h0);
      end
      begin
        for (int t = 0; t < 40; t++) begin
          out_ready = (t % 3 == 0);
          @(posedge clk); #1;
        end
        out_ready = 1'b1;
      end
    join
    drain();
    chk(ncap == 3, "R11 count", 34'(ncap), 34'd3);
    chk(cap[0] == {2'b10, 32'h00123456} && cap[1] == {2'b00, 32'h00FFFFFF}
        && cap[2] == {2'b01, 32'h00B65DC9}, "R11 order", cap[1], {2'b00, 32'h00FFFFFF});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule